// File: doc/BRIEF.md
# Callee-Saved Register Stacking Engine

This block performs the callee-saved half of exception-entry stacking for a small microcontroller core. When pulsed, it picks a stack pointer and an access privilege from the entry context. It then stores a nine-word frame through a single-word write port: an integrity signature followed by registers r4 to r11. The frame sits 40 bytes below the chosen pointer. The chosen pointer is moved down to the frame base even if a write was refused by memory protection.

The engine keeps its own copies of the two secure-bank stack pointers and returns their final values. An entry is either a fresh exception entry, which uses the currently active pointer and the current privilege, or a tail-chain, which derives both from fields of the exception-return value. If a write faults while faults are not being ignored, stacking stops at that word. The engine then repeats the entry once more as a tail-chain with faults ignored. On completion it returns the exception-return value with its callee-stacking bit forced high, a push-failed flag, a retry flag, and a one-cycle done pulse.

Top module: `csave_stack_engine`

## Requirements
- R1: The frame base is the selected pointer minus 40. The signature word 0xFEFA125B goes to base+0, registers r4..r11 go to base+8, base+12, ..., base+36, and base+4 is never written.
- R2: Writes are issued in the order signature, r4, r5, ... r11. A write's address, data and privilege stay stable while the port is not ready.
- R3: With faults not ignored, no write is issued after the first write whose fault response is high. With faults ignored, all nine writes are issued.
- R4: The selected pointer becomes the frame base whether or not a write faulted, and the other pointer keeps its value.
- R5: Stacking takes place only when exception-return bit 5 is 1, and is skipped on a tail-chain whose exception-return bit 0 is 1. A skipped pass issues no writes and changes no pointer.
- R6: On a tail-chain, the process pointer is used when bits 3 and 2 of the exception-return value are both 1, and the main pointer otherwise. Accesses are privileged when the secure nPRIV input is 0 or bit 3 is 0.
- R7: On a fresh entry, the process pointer is used when cur_psp_i is 1, and accesses take priv_cur_i as their privilege.
- R8: exc_ret_o equals exc_ret_i with bit 5 set.
- R9: If a pass faults while faults are not ignored, exactly one further pass runs as a tail-chain with faults ignored. retry_o is then 1 and push_fail_o is 1. push_fail_o is 1 exactly when any write faulted.
- R10: After reset, the engine is idle with wr_valid_o and done_o low. done_o is a single-cycle pulse once all passes finish, and priv_o holds the privilege of the last pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an entry sequence |
| tail_i | input | 1 | Entry is a tail-chain |
| ignore_i | input | 1 | Ignore write faults |
| exc_ret_i | input | XW | Incoming exception-return value |
| cur_psp_i | input | 1 | Process pointer is the active one (fresh entry) |
| priv_cur_i | input | 1 | Current privilege, 1 = privileged |
| npriv_s_i | input | 1 | Secure control unprivileged bit |
| sp_main_i | input | AW | Secure main stack pointer |
| sp_proc_i | input | AW | Secure process stack pointer |
| regs_i | input | NREG*DW | r4..r11, r4 in the low word |
| wr_valid_o | output | 1 | Write request |
| wr_addr_o | output | AW | Write byte address |
| wr_data_o | output | DW | Write data |
| wr_priv_o | output | 1 | Write is privileged |
| wr_ready_i | input | 1 | Write accepted this cycle |
| wr_fault_i | input | 1 | Protection fault for the accepted write |
| sp_main_o | output | AW | Final main stack pointer |
| sp_proc_o | output | AW | Final process stack pointer |
| priv_o | output | 1 | Privilege used by the last pass |
| exc_ret_o | output | XW | Outgoing exception-return value |
| push_fail_o | output | 1 | A write faulted |
| retry_o | output | 1 | A fault-ignoring retry pass ran |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Some properties are checked on every cycle. A stalled write must hold its address and data. No write may follow an unignored fault, and the port stays silent while idle. The completion pulse lasts one cycle, the outgoing exception-return value always carries the stacking bit, and a retry always comes with the failure flag. Other behaviour is shown only by the bench's scenarios, which compare against an independent model: the frame addresses and their ordering, the choice of pointer and privilege on fresh and tail-chained entries, the skip conditions, the pointer committed after a fault, and the full write sequence of the retry pass.

// File: rtl/csave_pkg.sv
package csave_pkg;
   localparam int ES_BIT    = 0;
   localparam int SPSEL_BIT = 2;
   localparam int MODE_BIT  = 3;
   localparam int DCRS_BIT  = 5;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_PASS,
      ST_WAIT,
      ST_FIN
   } eng_state_t;
endpackage

// File: rtl/csave_ctx_sel.sv
module csave_ctx_sel #(
   parameter int AW    = 32,
   parameter int FRAME = 40
) (
   input  logic          tail_i,
   input  logic          es_i,
   input  logic          spsel_i,
   input  logic          mode_i,
   input  logic          dcrs_i,
   input  logic          cur_psp_i,
   input  logic          priv_cur_i,
   input  logic          npriv_s_i,
   input  logic [AW-1:0] sp_main_i,
   input  logic [AW-1:0] sp_proc_i,
   output logic          do_stack_o,
   output logic          use_proc_o,
   output logic          priv_o,
   output logic [AW-1:0] base_o
);
   always_comb begin
      do_stack_o = dcrs_i && !(tail_i && es_i);
      if (tail_i) begin
         use_proc_o = mode_i && spsel_i;
         priv_o     = !npriv_s_i || !mode_i;
      end else begin
         use_proc_o = cur_psp_i;
         priv_o     = priv_cur_i;
      end
      base_o = (use_proc_o ? sp_proc_i : sp_main_i) - AW'(FRAME);
   end
endmodule

// File: rtl/csave_frame_writer.sv
module csave_frame_writer #(
   parameter int          AW   = 32,
   parameter int          DW   = 32,
   parameter int          NREG = 8,
   parameter logic [31:0] SIG  = 32'hFEFA125B
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go_i,
   input  logic             ign_i,
   input  logic [AW-1:0]    base_i,
   input  logic [NREG*DW-1:0] regs_i,
   input  logic             ready_i,
   input  logic             fault_i,
   output logic             valid_o,
   output logic [AW-1:0]    addr_o,
   output logic [DW-1:0]    data_o,
   output logic             fin_o,
   output logic             fault_o
);
   localparam int WB = DW / 8;
   localparam int NSLOT = NREG + 1;
   localparam int IW = $clog2(NSLOT);
   localparam logic [IW-1:0] LAST = IW'(NREG);

   logic [DW-1:0] slot_data [NSLOT];
   logic [AW-1:0] slot_off  [NSLOT];

   assign slot_data[0] = DW'(SIG);
   assign slot_off[0]  = '0;
   for (genvar g = 0; g < NREG; g++) begin : g_slot
      assign slot_data[g+1] = regs_i[g*DW +: DW];
      assign slot_off[g+1]  = AW'((g + 2) * WB);
   end

   logic          active_q, ign_q;
   logic [IW-1:0] idx_q;
   logic [AW-1:0] base_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         ign_q    <= 1'b0;
         idx_q    <= '0;
         base_q   <= '0;
         fin_o    <= 1'b0;
         fault_o  <= 1'b0;
      end else begin
         fin_o <= 1'b0;
         if (go_i) begin
            active_q <= 1'b1;
            ign_q    <= ign_i;
            idx_q    <= '0;
            base_q   <= base_i;
            fault_o  <= 1'b0;
         end else if (active_q && ready_i) begin
            if (fault_i) fault_o <= 1'b1;
            if ((fault_i && !ign_q) || idx_q == LAST) begin
               active_q <= 1'b0;
               fin_o    <= 1'b1;
            end else begin
               idx_q <= idx_q + 1'b1;
            end
         end
      end
   end

   assign valid_o = active_q;
   assign addr_o  = base_q + slot_off[idx_q];
   assign data_o  = slot_data[idx_q];

   // R2
   hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && !ready_i |=> valid_o && $stable(addr_o) && $stable(data_o));
   // R3
   stop_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && ready_i && fault_i && !ign_q |=> !valid_o);
endmodule

// File: rtl/csave_stack_engine.sv
module csave_stack_engine
   import csave_pkg::*;
#(
   parameter int          AW   = 32,
   parameter int          DW   = 32,
   parameter int          XW   = 32,
   parameter int          NREG = 8,
   parameter logic [31:0] SIG  = 32'hFEFA125B
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic               tail_i,
   input  logic               ignore_i,
   input  logic [XW-1:0]      exc_ret_i,
   input  logic               cur_psp_i,
   input  logic               priv_cur_i,
   input  logic               npriv_s_i,
   input  logic [AW-1:0]      sp_main_i,
   input  logic [AW-1:0]      sp_proc_i,
   input  logic [NREG*DW-1:0] regs_i,
   output logic               wr_valid_o,
   output logic [AW-1:0]      wr_addr_o,
   output logic [DW-1:0]      wr_data_o,
   output logic               wr_priv_o,
   input  logic               wr_ready_i,
   input  logic               wr_fault_i,
   output logic [AW-1:0]      sp_main_o,
   output logic [AW-1:0]      sp_proc_o,
   output logic               priv_o,
   output logic [XW-1:0]      exc_ret_o,
   output logic               push_fail_o,
   output logic               retry_o,
   output logic               done_o
);
   localparam int FRAME = (NREG + 2) * (DW / 8);

   if (DW % 8 != 0 || DW > 32) begin : g_bad_dw
      $error("DW must be a byte multiple no wider than the signature");
   end
   if (XW <= DCRS_BIT) begin : g_bad_xw
      $error("XW too narrow for the exception-return fields");
   end
   if (NREG < 1) begin : g_bad_nreg
      $error("NREG must be at least 1");
   end

   eng_state_t         st_q;
   logic               tail_q, ign_q, cur_psp_q, priv_cur_q, npriv_q;
   logic [XW-1:0]      lr_q;
   logic [AW-1:0]      main_q, proc_q;
   logic [NREG*DW-1:0] regs_q;
   logic               priv_q, fail_q, retry_q, done_q, go_q;

   logic          c_do, c_proc, c_priv;
   logic [AW-1:0] c_base;
   logic          w_fin, w_fault;

   csave_ctx_sel #(.AW(AW), .FRAME(FRAME)) u_ctx (
      .tail_i     (tail_q),
      .es_i       (lr_q[ES_BIT]),
      .spsel_i    (lr_q[SPSEL_BIT]),
      .mode_i     (lr_q[MODE_BIT]),
      .dcrs_i     (lr_q[DCRS_BIT]),
      .cur_psp_i  (cur_psp_q),
      .priv_cur_i (priv_cur_q),
      .npriv_s_i  (npriv_q),
      .sp_main_i  (main_q),
      .sp_proc_i  (proc_q),
      .do_stack_o (c_do),
      .use_proc_o (c_proc),
      .priv_o     (c_priv),
      .base_o     (c_base)
   );

   logic [AW-1:0] base_hold_q;

   csave_frame_writer #(.AW(AW), .DW(DW), .NREG(NREG), .SIG(SIG)) u_wr (
      .clk     (clk),
      .rst_n   (rst_n),
      .go_i    (go_q),
      .ign_i   (ign_q),
      .base_i  (base_hold_q),
      .regs_i  (regs_q),
      .ready_i (wr_ready_i),
      .fault_i (wr_fault_i),
      .valid_o (wr_valid_o),
      .addr_o  (wr_addr_o),
      .data_o  (wr_data_o),
      .fin_o   (w_fin),
      .fault_o (w_fault)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         tail_q      <= 1'b0;
         ign_q       <= 1'b0;
         cur_psp_q   <= 1'b0;
         priv_cur_q  <= 1'b0;
         npriv_q     <= 1'b0;
         lr_q        <= '0;
         main_q      <= '0;
         proc_q      <= '0;
         regs_q      <= '0;
         priv_q      <= 1'b0;
         fail_q      <= 1'b0;
         retry_q     <= 1'b0;
         done_q      <= 1'b0;
         go_q        <= 1'b0;
         base_hold_q <= '0;
      end else begin
         done_q <= 1'b0;
         go_q   <= 1'b0;
         case (st_q)
            ST_IDLE: if (start_i) begin
               tail_q     <= tail_i;
               ign_q      <= ignore_i;
               cur_psp_q  <= cur_psp_i;
               priv_cur_q <= priv_cur_i;
               npriv_q    <= npriv_s_i;
               lr_q       <= exc_ret_i;
               main_q     <= sp_main_i;
               proc_q     <= sp_proc_i;
               regs_q     <= regs_i;
               fail_q     <= 1'b0;
               retry_q    <= 1'b0;
               st_q       <= ST_PASS;
            end
            ST_PASS: begin
               priv_q         <= c_priv;
               lr_q[DCRS_BIT] <= 1'b1;
               if (c_do) begin
                  go_q        <= 1'b1;
                  base_hold_q <= c_base;
                  if (c_proc) proc_q <= c_base;
                  else        main_q <= c_base;
                  st_q <= ST_WAIT;
               end else begin
                  st_q <= ST_FIN;
               end
            end
            ST_WAIT: if (w_fin) begin
               fail_q <= fail_q | w_fault;
               if (w_fault && !ign_q) begin
                  retry_q <= 1'b1;
                  tail_q  <= 1'b1;
                  ign_q   <= 1'b1;
                  st_q    <= ST_PASS;
               end else begin
                  st_q <= ST_FIN;
               end
            end
            default: begin
               done_q <= 1'b1;
               st_q   <= ST_IDLE;
            end
         endcase
      end
   end

   assign wr_priv_o   = priv_q;
   assign sp_main_o   = main_q;
   assign sp_proc_o   = proc_q;
   assign priv_o      = priv_q;
   assign exc_ret_o   = lr_q;
   assign push_fail_o = fail_q;
   assign retry_o     = retry_q;
   assign done_o      = done_q;

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R8
   dcrs_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> exc_ret_o[DCRS_BIT]);
   // R9
   retry_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && retry_o |-> push_fail_o);
   // R5
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_q == ST_IDLE |-> !wr_valid_o);
endmodule

// File: tb/csave_stack_engine_bench.sv
module csave_stack_engine_bench;
   localparam int AW = 32, DW = 32, XW = 32, NREG = 8;
   localparam logic [31:0] SIG = 32'hFEFA125B;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n, start_i, tail_i, ignore_i, cur_psp_i, priv_cur_i, npriv_s_i;
   logic [XW-1:0] exc_ret_i;
   logic [AW-1:0] sp_main_i, sp_proc_i;
   logic [NREG*DW-1:0] regs_i;
   logic wr_valid_o, wr_priv_o, wr_ready_i, wr_fault_i;
   logic [AW-1:0] wr_addr_o, sp_main_o, sp_proc_o;
   logic [DW-1:0] wr_data_o;
   logic priv_o, push_fail_o, retry_o, done_o;
   logic [XW-1:0] exc_ret_o;

   logic fault_en, stall_en;
   logic [AW-1:0] fault_addr;
   logic [2:0] rcnt;

   assign wr_fault_i = fault_en && (wr_addr_o == fault_addr);
   assign wr_ready_i = stall_en ? (rcnt != 3'd2 && rcnt != 3'd5) : 1'b1;

   csave_stack_engine u_csave_stack_engine (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .tail_i(tail_i),
      .ignore_i(ignore_i), .exc_ret_i(exc_ret_i), .cur_psp_i(cur_psp_i),
      .priv_cur_i(priv_cur_i), .npriv_s_i(npriv_s_i), .sp_main_i(sp_main_i),
      .sp_proc_i(sp_proc_i), .regs_i(regs_i), .wr_valid_o(wr_valid_o),
      .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .wr_priv_o(wr_priv_o),
      .wr_ready_i(wr_ready_i), .wr_fault_i(wr_fault_i), .sp_main_o(sp_main_o),
      .sp_proc_o(sp_proc_o), .priv_o(priv_o), .exc_ret_o(exc_ret_o),
      .push_fail_o(push_fail_o), .retry_o(retry_o), .done_o(done_o));

   int n_chk = 0, n_fail = 0;
   logic [AW+DW:0] exp_q[$];
   logic [AW-1:0] m_main, m_proc;
   logic m_priv;

   always @(posedge clk) rcnt <= rst_n ? rcnt + 3'd1 : 3'd0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Scoreboard monitor: R1 R2 R3 word-by-word compare
   always @(negedge clk) begin
      if (rst_n && wr_valid_o && wr_ready_i) begin
         if (exp_q.size() == 0) chk("R3 unexpected write", {wr_priv_o, wr_addr_o, wr_data_o}, '0);
         else chk("R1/R2 write", {wr_priv_o, wr_addr_o, wr_data_o}, exp_q.pop_front());
      end
   end

   task automatic model_pass(input logic tail, input logic ign, input logic [XW-1:0] lr,
                             output logic pf);
      logic stk, up;
      logic [AW-1:0] base, a;
      pf = 1'b0;
      m_priv = tail ? (!npriv_s_i || !lr[3]) : priv_cur_i;
      stk = lr[5] && !(tail && lr[0]);
      if (stk) begin
         up = tail ? (lr[3] && lr[2]) : cur_psp_i;
         base = (up ? m_proc : m_main) - 32'd40;
         for (int k = 0; k < 9; k++) begin
            a = (k == 0) ? base : base + 32'(4 * k + 4);
            exp_q.push_back({m_priv, a, (k == 0) ? SIG : regs_i[(k-1)*DW +: DW]});
            if (fault_en && a == fault_addr) begin
               pf = 1'b1;
               if (!ign) break;
            end
         end
         if (up) m_proc = base;
         else    m_main = base;
      end
   endtask

   task automatic run(input string tag, input logic tail, input logic ign,
                      input logic [XW-1:0] lr, input logic [AW-1:0] smain,
                      input logic [AW-1:0] sproc, input logic psp, input logic pcur,
                      input logic np, input logic [7:0] seed);
      logic pf1, pf2, rt;
      int wd;
      tail_i = tail; ignore_i = ign; exc_ret_i = lr; sp_main_i = smain;
      sp_proc_i = sproc; cur_psp_i = psp; priv_cur_i = pcur; npriv_s_i = np;
      for (int k = 0; k < NREG; k++) regs_i[k*DW +: DW] = {seed, 16'h5A00, 8'(k + 4)};
      m_main = smain; m_proc = sproc; pf2 = 1'b0;
      model_pass(tail, ign, lr, pf1);
      rt = pf1 && !ign;
      if (rt) model_pass(1'b1, 1'b1, lr | 32'h20, pf2);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      wd = 0;
      while (!done_o && wd < 500) begin
         @(negedge clk);
         wd++;
      end
      chk({tag, " R10 done seen"}, 64'(done_o), 64'd1);
      chk({tag, " R4 main ptr"}, 64'(sp_main_o), 64'(m_main));
      chk({tag, " R4 proc ptr"}, 64'(sp_proc_o), 64'(m_proc));
      chk({tag, " R8 exc_ret"}, 64'(exc_ret_o), 64'(lr | 32'h20));
      chk({tag, " R9 push_fail"}, 64'(push_fail_o), 64'(pf1 | pf2));
      chk({tag, " R9 retry"}, 64'(retry_o), 64'(rt));
      chk({tag, " R6/R7 priv"}, 64'(priv_o), 64'(m_priv));
      chk({tag, " R3 writes left"}, 64'(exp_q.size()), 64'd0);
      exp_q.delete();
      @(negedge clk);
      chk({tag, " R10 done pulse width"}, 64'(done_o), 64'd0);
   endtask

   initial begin
      #(20 * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; start_i = 1'b0; tail_i = 1'b0; ignore_i = 1'b0;
      exc_ret_i = '0; cur_psp_i = 1'b0; priv_cur_i = 1'b0; npriv_s_i = 1'b0;
      sp_main_i = '0; sp_proc_i = '0; regs_i = '0;
      fault_en = 1'b0; stall_en = 1'b0; fault_addr = '0;
      repeat (3) @(negedge clk);
      chk("R10 reset valid", 64'(wr_valid_o), 64'd0);
      chk("R10 reset done", 64'(done_o), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 R2 R7: fresh entry on main pointer, privileged
      run("fresh-main", 0, 0, 32'hFFFF_FFF8, 32'h2000_1000, 32'h2000_2000, 0, 1, 0, 8'h11);
      // R7: fresh entry on process pointer, unprivileged, with stalls (R2)
      stall_en = 1'b1;
      run("fresh-proc", 0, 0, 32'hFFFF_FFFC, 32'h2000_1000, 32'h2000_2000, 1, 0, 0, 8'h22);
      // R5: stacking bit clear
      run("no-dcrs", 0, 0, 32'hFFFF_FFDC, 32'h2000_1000, 32'h2000_2000, 0, 1, 0, 8'h33);
      // R5: tail-chain with bit 0 set
      run("tail-es", 1, 0, 32'hFFFF_FFFD, 32'h2000_1000, 32'h2000_2000, 0, 1, 0, 8'h44);
      // R6: tail-chain thread mode, process, nPRIV set => unprivileged
      run("tail-proc", 1, 0, 32'hFFFF_FFBC, 32'h2000_3000, 32'h2000_4000, 0, 1, 1, 8'h55);
      // R6: tail-chain handler mode => main, privileged
      run("tail-hnd", 1, 0, 32'hFFFF_FFB4, 32'h2000_3000, 32'h2000_4000, 1, 0, 1, 8'h66);
      // R3 R9: fault on r5 word, not ignored => stop and retry
      fault_en = 1'b1; fault_addr = 32'h2000_0FE4;
      run("fault-retry", 0, 0, 32'hFFFF_FFF8, 32'h2000_1000, 32'h2000_2000, 0, 1, 1, 8'h77);
      // R3: fault ignored => all nine writes, no retry
      run("fault-ign", 0, 1, 32'hFFFF_FFF8, 32'h2000_1000, 32'h2000_2000, 0, 1, 0, 8'h88);
      // R3 R9: fault on signature word, retry lands on process pointer
      fault_addr = 32'h2000_0FD8; stall_en = 1'b0;
      run("fault-sig", 0, 0, 32'hFFFF_FFFC, 32'h2000_1000, 32'h2000_2000, 0, 1, 0, 8'h99);
      fault_en = 1'b0;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule